// File: doc/BRIEF.md
# Burst-Coalescing Memory Request Unit

This unit sits between a kernel datapath that issues single-word memory requests and a global memory port that can handle bursts. Each request is a read or a write of one word at a word address. When the requests follow on one another (each address is one more than the last, and the direction does not change), the unit holds them in a gathering buffer. It then sends the whole run to memory as one command that carries the start address and a word count.

A pending run goes to memory in one of three cases. The first is that the buffer reaches its maximum length. The second is that a request arrives whose address or direction breaks the run. The third is that no new request is accepted for a set number of idle cycles. Write data leaves after its command, as a stream of beats in request order. Read data comes back from memory with variable latency and in command order, and the unit hands it to the requester in the order the reads were accepted. Every channel uses a valid/ready handshake.

Top module: `bc_coalescer`

## Requirements
- R1: After reset `cmd_valid` and `wr_valid` are low, and `req_ready` is high.
- R2: Accepted requests that share a direction and have consecutive word addresses form one command. `cmd_addr` is the first address, `cmd_len` is the number of words, and `cmd_write` is 1 for a write and 0 for a read.
- R3: When a run reaches `MAX_BURST` words, the command is raised in the cycle after the last word is accepted, with `cmd_len` equal to `MAX_BURST`. Requests that follow start a new run.
- R4: A request whose address is not the pending run's start address plus its count is not accepted. The pending run is issued first, and the request is then accepted as the first word of a new run.
- R5: A request whose direction differs from the pending run's direction flushes the run in the same way as an address break.
- R6: A partial run is issued after `IDLE_LIMIT` consecutive cycles in which no request is accepted. `cmd_valid` rises exactly `IDLE_LIMIT` clock edges after the edge that accepted the last word, and not earlier.
- R7: For a write command, exactly `cmd_len` data beats follow the command handshake, in request order. `wr_last` is high on the final beat only. Command and data never overlap, and a stalled beat holds its value.
- R8: Read data is passed to the requester in the order the reads were accepted, and the requester's `rsp_ready` back-pressures the memory read channel.
- R9: While a command or its write data is pending, `req_ready` is low. A stalled command holds its address, length and direction.
- R10: `cmd_len` is never 0 and never larger than `MAX_BURST`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request accepted this cycle if valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW | Word address |
| req_wdata | input | DW | Write word |
| rsp_valid | output | 1 | Read response valid |
| rsp_ready | input | 1 | Requester can take a response |
| rsp_rdata | output | DW | Read response word |
| cmd_valid | output | 1 | Memory command valid |
| cmd_ready | input | 1 | Memory takes the command |
| cmd_write | output | 1 | Command direction, 1 = write |
| cmd_addr | output | AW | First word address of the burst |
| cmd_len | output | LW | Burst length in words |
| wr_valid | output | 1 | Write beat valid |
| wr_ready | input | 1 | Memory takes the write beat |
| wr_data | output | DW | Write beat data |
| wr_last | output | 1 | Final beat of the burst |
| rd_valid | input | 1 | Memory read beat valid |
| rd_ready | output | 1 | Unit takes the read beat |
| rd_data | input | DW | Memory read beat data |

## Verification
The properties assume three things about the inputs. A requester holds `req_valid`, `req_write`, `req_addr` and `req_wdata` steady until they are accepted. Memory returns read words in command order. Memory never returns more read words than it was asked for. The bench drives each request at a falling edge and keeps it unchanged until it sees `req_ready`. Its memory model queues the words of every read command and returns them strictly first-in first-out, with gaps. Ready and valid on every channel toggle in fixed patterns, so every stall path is exercised without breaking these assumptions.

// File: rtl/bc_pkg.sv
`timescale 1ns/1ps
package bc_pkg;
  typedef enum logic [1:0] {
    BC_GATHER = 2'd0,
    BC_CMD    = 2'd1,
    BC_WDATA  = 2'd2
  } bc_state_e;
endpackage

// File: rtl/bc_wbuf.sv
`timescale 1ns/1ps
module bc_wbuf #(
  parameter int DEPTH = 16,
  parameter int W     = 32,
  localparam int IW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          we,
  input  logic [IW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [IW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  logic [W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem_q[waddr] <= wdata;
  end

  assign rdata = mem_q[raddr];
endmodule

// File: rtl/bc_idle_timer.sv
`timescale 1ns/1ps
module bc_idle_timer #(
  parameter int LIMIT = 32,
  localparam int TW   = $clog2(LIMIT + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic arm,
  input  logic kick,
  output logic expired
);
  logic [TW-1:0] idle_q;

  assign expired = arm && !kick && (idle_q == TW'(LIMIT - 1));

  always_ff @(posedge clk) begin
    if (!rst_n)            idle_q <= '0;
    else if (!arm || kick) idle_q <= '0;
    else if (!expired)     idle_q <= idle_q + 1'b1;
  end
endmodule

// File: rtl/bc_coalescer.sv
`timescale 1ns/1ps
module bc_coalescer
  import bc_pkg::*;
#(
  parameter int AW         = 32,
  parameter int DW         = 32,
  parameter int MAX_BURST  = 16,
  parameter int IDLE_LIMIT = 32,
  localparam int LW        = $clog2(MAX_BURST + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_write,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic          rsp_valid,
  input  logic          rsp_ready,
  output logic [DW-1:0] rsp_rdata,
  output logic          cmd_valid,
  input  logic          cmd_ready,
  output logic          cmd_write,
  output logic [AW-1:0] cmd_addr,
  output logic [LW-1:0] cmd_len,
  output logic          wr_valid,
  input  logic          wr_ready,
  output logic [DW-1:0] wr_data,
  output logic          wr_last,
  input  logic          rd_valid,
  output logic          rd_ready,
  input  logic [DW-1:0] rd_data
);
  localparam int IW = (MAX_BURST > 1) ? $clog2(MAX_BURST) : 1;

  // run-continuation test: same direction and next address in sequence
  function automatic logic breaks_run(input logic dir, input logic [AW-1:0] base,
                                      input logic [LW-1:0] cnt, input logic wr,
                                      input logic [AW-1:0] addr);
    return (cnt != '0) && ((wr != dir) || (addr != base + AW'(cnt)));
  endfunction

  function automatic logic final_beat(input logic [IW-1:0] beat, input logic [LW-1:0] cnt);
    return beat == IW'(cnt - 1'b1);
  endfunction

  bc_state_e     state_q;
  logic [AW-1:0] base_q;
  logic [LW-1:0] cnt_q;
  logic          dir_q;
  logic [IW-1:0] beat_q;

  // named internal events
  logic gathering, run_break, ev_accept, ev_full, ev_brk, ev_timeout, ev_flush;
  logic ev_cmd_fire, ev_beat;

  assign gathering   = (state_q == BC_GATHER);
  assign run_break   = breaks_run(dir_q, base_q, cnt_q, req_write, req_addr);
  assign req_ready   = gathering && !run_break;
  assign ev_accept   = req_valid && req_ready;
  assign ev_full     = ev_accept && (cnt_q == LW'(MAX_BURST - 1));
  assign ev_brk      = gathering && req_valid && run_break;
  assign ev_flush    = ev_full || ev_brk || ev_timeout;
  assign ev_cmd_fire = cmd_valid && cmd_ready;
  assign ev_beat     = wr_valid && wr_ready;

  bc_idle_timer #(.LIMIT(IDLE_LIMIT)) timer_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .arm     (gathering && (cnt_q != '0)),
    .kick    (ev_accept),
    .expired (ev_timeout)
  );

  bc_wbuf #(.DEPTH(MAX_BURST), .W(DW)) wbuf_i (
    .clk   (clk),
    .we    (ev_accept && req_write),
    .waddr (cnt_q[IW-1:0]),
    .wdata (req_wdata),
    .raddr (beat_q),
    .rdata (wr_data)
  );

  assign cmd_valid = (state_q == BC_CMD);
  assign cmd_addr  = base_q;
  assign cmd_len   = cnt_q;
  assign cmd_write = dir_q;
  assign wr_valid  = (state_q == BC_WDATA);
  assign wr_last   = wr_valid && final_beat(beat_q, cnt_q);

  // read data returns in command order; pass it straight through
  assign rsp_valid = rd_valid;
  assign rsp_rdata = rd_data;
  assign rd_ready  = rsp_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= BC_GATHER;
      base_q  <= '0;
      cnt_q   <= '0;
      dir_q   <= 1'b0;
      beat_q  <= '0;
    end else begin
      unique case (state_q)
        BC_GATHER: begin
          if (ev_accept) begin
            if (cnt_q == '0) begin
              base_q <= req_addr;
              dir_q  <= req_write;
            end
            cnt_q <= cnt_q + 1'b1;
          end
          if (ev_flush) state_q <= BC_CMD;
        end
        BC_CMD: begin
          if (ev_cmd_fire) begin
            beat_q <= '0;
            if (dir_q) begin
              state_q <= BC_WDATA;
            end else begin
              cnt_q   <= '0;
              state_q <= BC_GATHER;
            end
          end
        end
        BC_WDATA: begin
          if (ev_beat) begin
            beat_q <= beat_q + 1'b1;
            if (wr_last) begin
              cnt_q   <= '0;
              state_q <= BC_GATHER;
            end
          end
        end
        default: state_q <= BC_GATHER;
      endcase
    end
  end
endmodule

// File: rtl/bc_coalescer_chk.sv
`timescale 1ns/1ps
module bc_coalescer_chk #(
  parameter int AW        = 32,
  parameter int DW        = 32,
  parameter int MAX_BURST = 16,
  parameter int LW        = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_ready,
  input logic          cmd_valid,
  input logic          cmd_ready,
  input logic          cmd_write,
  input logic [AW-1:0] cmd_addr,
  input logic [LW-1:0] cmd_len,
  input logic          wr_valid,
  input logic          wr_ready,
  input logic [DW-1:0] wr_data,
  input logic          wr_last,
  input logic          ev_full,
  input logic          ev_brk,
  input logic          ev_timeout
);
  AST_CMD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && !cmd_ready |=> cmd_valid && $stable(cmd_addr) && $stable(cmd_len) && $stable(cmd_write)); // R9
  AST_BUSY_BLOCKS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid || wr_valid) |-> !req_ready); // R9
  AST_WR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && !wr_ready |=> wr_valid && $stable(wr_data) && $stable(wr_last)); // R7
  AST_CMD_DATA_APART: assert property (@(posedge clk) disable iff (!rst_n)
    !(cmd_valid && wr_valid)); // R7
  AST_LEN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> (cmd_len != '0) && (int'(cmd_len) <= MAX_BURST)); // R10
  AST_FULL_ISSUE: assert property (@(posedge clk) disable iff (!rst_n)
    ev_full |=> cmd_valid && (int'(cmd_len) == MAX_BURST)); // R3
  AST_BREAK_ISSUE: assert property (@(posedge clk) disable iff (!rst_n)
    ev_brk |=> cmd_valid); // R4
  AST_IDLE_ISSUE: assert property (@(posedge clk) disable iff (!rst_n)
    ev_timeout |=> cmd_valid); // R6
endmodule

bind bc_coalescer bc_coalescer_chk #(
  .AW(AW), .DW(DW), .MAX_BURST(MAX_BURST), .LW(LW)
) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_ready  (req_ready),
  .cmd_valid  (cmd_valid),
  .cmd_ready  (cmd_ready),
  .cmd_write  (cmd_write),
  .cmd_addr   (cmd_addr),
  .cmd_len    (cmd_len),
  .wr_valid   (wr_valid),
  .wr_ready   (wr_ready),
  .wr_data    (wr_data),
  .wr_last    (wr_last),
  .ev_full    (ev_full),
  .ev_brk     (ev_brk),
  .ev_timeout (ev_timeout)
);

// File: tb/bc_coalescer_tb_top.sv
`timescale 1ns/1ps
module bc_coalescer_tb_top;
  localparam int AW = 32, DW = 32, MAXB = 16, IDLE = 8;
  localparam int LW = $clog2(MAXB + 1);

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic req_ready, rsp_valid, rsp_ready = 1'b1;
  logic [DW-1:0] rsp_rdata;
  logic cmd_valid, cmd_ready = 1'b0, cmd_write;
  logic [AW-1:0] cmd_addr;
  logic [LW-1:0] cmd_len;
  logic wr_valid, wr_ready = 1'b0, wr_last;
  logic [DW-1:0] wr_data;
  logic rd_valid = 1'b0, rd_ready;
  logic [DW-1:0] rd_data = '0;

  always #5 clk = ~clk;

  bc_coalescer #(.AW(AW), .DW(DW), .MAX_BURST(MAXB), .IDLE_LIMIT(IDLE)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_write(cmd_write),
    .cmd_addr(cmd_addr), .cmd_len(cmd_len),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_data(wr_data), .wr_last(wr_last),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_data(rd_data)
  );

  int total = 0, bad = 0, cyc = 0;
  bit hold_cmd = 1'b0, done = 1'b0;
  logic [31:0] log_addr[$];
  int          log_len[$];
  bit          log_wr[$];
  logic [31:0] wd_log[$];
  bit          wl_log[$];
  logic [31:0] pend[$];
  logic [31:0] exp_rd[$];

  function automatic logic [31:0] fmem(input logic [31:0] a);
    return {a[15:0] ^ 16'h5A5A, ~a[15:0]};
  endfunction
  function automatic logic [31:0] wpat(input logic [31:0] a);
    return a * 7 + 3;
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // memory model: command/write acceptance and in-order read return
  initial begin
    forever begin
      @(negedge clk);
      cyc++;
      cmd_ready = !hold_cmd && (cyc % 3 != 1);
      wr_ready  = (cyc % 4 != 2);
      rd_valid  = (pend.size() != 0) && (cyc % 5 != 3);
      rd_data   = (pend.size() != 0) ? fmem(pend[0]) : '0;
      #1;
      if (cmd_valid && cmd_ready) begin
        log_addr.push_back(cmd_addr);
        log_len.push_back(int'(cmd_len));
        log_wr.push_back(cmd_write);
        if (!cmd_write)
          for (int k = 0; k < int'(cmd_len); k++) pend.push_back(cmd_addr + k);
      end
      if (wr_valid && wr_ready) begin
        wd_log.push_back(wr_data);
        wl_log.push_back(wr_last);
      end
      if (rd_valid && rd_ready) void'(pend.pop_front());
    end
  end

  // requester side response checker (R8)
  initial begin
    forever begin
      @(negedge clk);
      rsp_ready = (cyc % 7 != 5);
      #1;
      if (rst_n && rsp_valid && rsp_ready) begin
        if (exp_rd.size() == 0) chk(1'b0, "R8", "unexpected response", rsp_rdata, 0);
        else begin
          logic [31:0] a;
          a = exp_rd.pop_front();
          chk(rsp_rdata == fmem(a), "R8", "read order/data", rsp_rdata, fmem(a));
        end
      end
    end
  end

  task automatic send(input bit wr, input logic [31:0] a);
    forever begin
      @(negedge clk);
      req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = wpat(a);
      #1;
      if (req_ready) break;
    end
    if (!wr) exp_rd.push_back(a);
    @(posedge clk);
  endtask

  task automatic go_idle();
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic wait_cmds(input int n, input string req);
    for (int i = 0; i < 400 && log_addr.size() < n; i++) @(negedge clk);
    repeat (2) @(negedge clk);
    chk(log_addr.size() == n, req, "command count", log_addr.size(), n);
  endtask

  task automatic check_cmd(input int i, input logic [31:0] a, input int len, input bit wr, input string req);
    chk(log_addr[i] == a, req, "cmd_addr", log_addr[i], a);
    chk(log_len[i] == len, req, "cmd_len", log_len[i], len);
    chk(log_wr[i] == wr, req, "cmd_write", log_wr[i], wr);
  endtask

  task automatic check_beats(input int wi, input logic [31:0] a, input int len);
    for (int k = 0; k < len; k++) begin
      chk(wd_log[wi+k] == wpat(a + k), "R7", "write beat data", wd_log[wi+k], wpat(a + k));
      chk(wl_log[wi+k] == (k == len - 1), "R7", "wr_last", wl_log[wi+k], (k == len - 1));
    end
  endtask

  task automatic drain_reads();
    for (int i = 0; i < 600 && (exp_rd.size() != 0); i++) @(negedge clk);
    chk(exp_rd.size() == 0, "R8", "responses outstanding", exp_rd.size(), 0);
  endtask

  task automatic t_reset();
    @(negedge clk); #2;
    chk(cmd_valid == 1'b0, "R1", "cmd_valid after reset", cmd_valid, 0);
    chk(wr_valid == 1'b0, "R1", "wr_valid after reset", wr_valid, 0);
    chk(req_ready == 1'b1, "R1", "req_ready after reset", req_ready, 1);
  endtask

  task automatic t_full_write();
    int n0 = log_addr.size(), w0 = wd_log.size();
    for (int k = 0; k < MAXB; k++) send(1'b1, 32'h100 + k);
    @(negedge clk); req_valid = 1'b0; #2;
    chk(cmd_valid == 1'b1, "R3", "cmd raised after last word", cmd_valid, 1);
    chk(int'(cmd_len) == MAXB, "R3", "full length", cmd_len, MAXB);
    wait_cmds(n0 + 1, "R3");
    check_cmd(n0, 32'h100, MAXB, 1'b1, "R2");
    for (int i = 0; i < 100 && wd_log.size() < w0 + MAXB; i++) @(negedge clk);
    check_beats(w0, 32'h100, MAXB);
  endtask

  task automatic t_addr_break();
    int n0 = log_addr.size(), w0 = wd_log.size();
    for (int k = 0; k < 3; k++) send(1'b1, 32'h200 + k);
    send(1'b1, 32'h300);
    go_idle();
    wait_cmds(n0 + 2, "R4");
    check_cmd(n0, 32'h200, 3, 1'b1, "R4");
    check_cmd(n0 + 1, 32'h300, 1, 1'b1, "R4");
    check_beats(w0, 32'h200, 3);
    check_beats(w0 + 3, 32'h300, 1);
  endtask

  task automatic t_dir_change();
    int n0 = log_addr.size(), w0 = wd_log.size();
    send(1'b0, 32'h400);
    send(1'b0, 32'h401);
    send(1'b1, 32'h402);
    go_idle();
    wait_cmds(n0 + 2, "R5");
    check_cmd(n0, 32'h400, 2, 1'b0, "R5");
    check_cmd(n0 + 1, 32'h402, 1, 1'b1, "R5");
    check_beats(w0, 32'h402, 1);
    drain_reads();
  endtask

  task automatic t_idle_flush();
    int n0 = log_addr.size();
    for (int k = 0; k < 3; k++) send(1'b0, 32'h800 + k);
    go_idle();
    repeat (IDLE - 1) @(negedge clk);
    #2;
    chk(cmd_valid == 1'b0, "R6", "no command before idle limit", cmd_valid, 0);
    @(negedge clk); #2;
    chk(cmd_valid == 1'b1, "R6", "command at idle limit", cmd_valid, 1);
    wait_cmds(n0 + 1, "R6");
    check_cmd(n0, 32'h800, 3, 1'b0, "R6");
    drain_reads();
  endtask

  task automatic t_long_read();
    int n0 = log_addr.size();
    for (int k = 0; k < MAXB + 4; k++) send(1'b0, 32'h1000 + k);
    go_idle();
    wait_cmds(n0 + 2, "R10");
    check_cmd(n0, 32'h1000, MAXB, 1'b0, "R3");
    check_cmd(n0 + 1, 32'h1000 + MAXB, 4, 1'b0, "R10");
    drain_reads();
  endtask

  task automatic t_hold();
    int n0 = log_addr.size(), w0 = wd_log.size();
    hold_cmd = 1'b1;
    for (int k = 0; k < MAXB; k++) send(1'b1, 32'h500 + k);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      req_valid = 1'b1; req_write = 1'b1; req_addr = 32'h510; req_wdata = wpat(32'h510);
      #2;
      chk(req_ready == 1'b0, "R9", "req_ready while command pending", req_ready, 0);
      chk(cmd_valid && cmd_addr == 32'h500, "R9", "stalled command held", cmd_addr, 32'h500);
    end
    @(negedge clk); req_valid = 1'b0;
    hold_cmd = 1'b0;
    wait_cmds(n0 + 1, "R9");
    check_cmd(n0, 32'h500, MAXB, 1'b1, "R9");
    for (int i = 0; i < 100 && wd_log.size() < w0 + MAXB; i++) @(negedge clk);
    check_beats(w0, 32'h500, MAXB);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_full_write();
    t_addr_break();
    t_dir_change();
    t_idle_flush();
    t_long_read();
    t_hold();
    repeat (5) @(negedge clk);
    if (!done) begin
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      total++; bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule